// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block gathers interrupt requests from a set of external pins. Each pin is brought into the clock domain through a short synchroniser. A per-channel detector then watches it for one of four conditions: a low level, a high level, a rising edge or a falling edge. When the chosen condition occurs, the detector sets a sticky request flag. A channel raises its interrupt request output only while both its flag and its enable are 1.

Software reaches the block through a 16-bit register port with two words. Word 0 holds the request flags in the upper byte and the enables in the lower byte. Word 1 holds the two-bit detection selects. A flag clears only where software writes a 0 to it. Writing a 1 leaves the flag alone, so one channel can be acknowledged without touching the others. A read tagged as part of a read-modify-write returns 1 in every implemented flag position. Writing that value back therefore cannot clear pending requests by accident. A data-transfer service that handles a channel's request raises a one-cycle completion strobe, and that strobe clears the channel's flag without any software write.

The channel set is sparse. Flag positions that have no channel read 0, ignore writes and never raise a request. Pins are expected to idle high: the synchroniser stages reset to 1, so the default low-level mode does not fire at reset release.

Top module: `eifc_top`

## Requirements
- R1: After reset, every flag, enable and detection select is 0, `irq_o` is all 0 and `reg_rdata_o` is 0.
- R2: With default parameters, only channels 0, 4, 5, 6 and 7 exist. Channel i's flag is word-0 bit 8+i and its enable is word-0 bit i. Word-0 bits 9 to 11 and 1 to 3 always read 0, writes to them are ignored, and `irq_o[3:1]` stays 0 whatever is done to pins 1 to 3.
- R3: The detection select of channel i sits in word-1 bits 2i+1:2i and is encoded as 00 low level, 01 high level, 10 rising edge, 11 falling edge. A pin change applied between two clock edges sets the flag on the third rising edge after it.
- R4: A write to word 0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Other channels are never disturbed.
- R5: `reg_rdata_o` is registered. It shows the addressed word from the first edge that samples `reg_rd_i`. With `reg_rmw_i` high, the implemented flag bits read 1 while the enable bits read their true value.
- R6: `irq_o[i]` equals the AND of flag i and enable i, delayed by one register stage.
- R7: A one-cycle pulse on `xfer_done_i[i]` clears flag i only.
- R8: If a detection and a clear (written 0 or transfer completion) occur in the same cycle, the flag ends at 1. While a level condition stays active, clears therefore leave the flag set.
- R9: Word 1 reads back the written selects for implemented channels and 0 in the fields of absent channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous external request pins, one per channel |
| xfer_done_i | input | 8 | Per-channel transfer-complete strobes |
| reg_addr_i | input | 1 | Word select: 0 flags/enables, 1 detection selects |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rmw_i | input | 1 | Marks a read as part of a read-modify-write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 8 | Registered per-channel interrupt requests |

## Verification
A flag that is stuck, wrongly set or wrongly cleared shows up at `irq_o` one cycle after the flag register changes, provided the channel is enabled. It also shows up in word 0 on the next read. A wrong detection select or a wrong synchroniser depth moves the flag-set edge away from the third clock after the pin change, which a read issued at that exact edge exposes. A clear that reaches the wrong bit appears as a changed neighbouring flag on the next read of word 0.

// File: rtl/eifc_pkg.sv
package eifc_pkg;

  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;

  typedef enum logic {
    WORD_FLAGS = 1'b0,
    WORD_SEL   = 1'b1
  } reg_word_e;

  // Condition test on the synchronised sample and its one-cycle-older copy
  function automatic logic det_hit(det_mode_e mode, logic cur, logic prev);
    case (mode)
      DET_LOW:  det_hit = ~cur;
      DET_HIGH: det_hit = cur;
      DET_RISE: det_hit = cur & ~prev;
      default:  det_hit = ~cur & prev;
    endcase
  endfunction

endpackage

// File: rtl/eifc_sync.sv
module eifc_sync #(
  parameter int   W       = 8,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);

  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) st[k] <= {W{RST_VAL}};
    end else begin
      st[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) st[k] <= st[k-1];
    end
  end

  assign q_o      = st[STAGES-1];
  assign q_prev_o = st[STAGES];

endmodule

// File: rtl/eifc_chan.sv
module eifc_chan
  import eifc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cur_i,
  input  logic      prev_i,
  input  det_mode_e mode_i,
  input  logic      sw_clr_i,
  input  logic      xfer_clr_i,
  output logic      flag_o
);

  logic det;
  logic clr;
  logic flag_q;

  assign det = det_hit(mode_i, cur_i, prev_i);
  assign clr = sw_clr_i | xfer_clr_i;

  // set has priority over either clear source
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (det) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    det |=> flag_q); // R8
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sw_clr_i && !det) |=> !flag_q); // R4
  AST_XFER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (xfer_clr_i && !det) |=> !flag_q); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!clr && flag_q) |=> flag_q); // R4

endmodule

// File: rtl/eifc_top.sv
module eifc_top
  import eifc_pkg::*;
#(
  parameter int             NCH         = 8,
  parameter logic [NCH-1:0] CH_PRESENT  = 8'hF1,
  parameter int             FLAG_LSB    = 8,
  parameter int             SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pin_i,
  input  logic [NCH-1:0]   xfer_done_i,
  input  logic             reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic             reg_rmw_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [NCH-1:0]   irq_o
);

  localparam int SEL_W = 2 * NCH;

  function automatic logic [SEL_W-1:0] widen(input logic [NCH-1:0] p);
    logic [SEL_W-1:0] m;
    for (int i = 0; i < NCH; i++) m[2*i +: 2] = {2{p[i]}};
    return m;
  endfunction

  localparam logic [SEL_W-1:0] SEL_MASK = widen(CH_PRESENT);

  logic [NCH-1:0]   cur;
  logic [NCH-1:0]   prev;
  logic [NCH-1:0]   flag;
  logic [NCH-1:0]   en_q;
  logic [SEL_W-1:0] sel_q;
  logic [NCH-1:0]   sw_clr;
  logic [NCH-1:0]   irq_q;
  logic [REG_W-1:0] rdata_q;
  logic [REG_W-1:0] rd_word;
  logic             wr_flags;
  logic             wr_sel;

  eifc_sync #(
    .W      (NCH),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_i     (pin_i),
    .q_o     (cur),
    .q_prev_o(prev)
  );

  assign wr_flags = reg_wr_i && (reg_word_e'(reg_addr_i) == WORD_FLAGS);
  assign wr_sel   = reg_wr_i && (reg_word_e'(reg_addr_i) == WORD_SEL);
  assign sw_clr   = wr_flags ? ~reg_wdata_i[FLAG_LSB +: NCH] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      if (wr_flags) en_q  <= reg_wdata_i[NCH-1:0] & CH_PRESENT;
      if (wr_sel)   sel_q <= reg_wdata_i[SEL_W-1:0] & SEL_MASK;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (CH_PRESENT[i]) begin : g_on
      eifc_chan u_chan (
        .clk       (clk),
        .rst       (rst),
        .cur_i     (cur[i]),
        .prev_i    (prev[i]),
        .mode_i    (det_mode_e'(sel_q[2*i +: 2])),
        .sw_clr_i  (sw_clr[i]),
        .xfer_clr_i(xfer_done_i[i]),
        .flag_o    (flag[i])
      );
    end else begin : g_off
      assign flag[i] = 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (reg_word_e'(reg_addr_i) == WORD_FLAGS) begin
      rd_word[FLAG_LSB +: NCH] = reg_rmw_i ? CH_PRESENT : flag;
      rd_word[NCH-1:0]         = en_q;
    end else begin
      rd_word[SEL_W-1:0] = sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= '0;
    end else begin
      if (reg_rd_i) rdata_q <= rd_word;
      irq_q <= flag & en_q;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(flag & en_q))); // R6
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((irq_o & ~CH_PRESENT) == '0) && ((flag & ~CH_PRESENT) == '0)); // R2
  AST_RMW_ONES: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_rmw_i && !reg_addr_i) |=>
      (reg_rdata_o[FLAG_LSB +: NCH] == CH_PRESENT)); // R5
  AST_SEL_ABSENT: assert property (@(posedge clk) disable iff (rst)
    (sel_q & ~SEL_MASK) == '0); // R9

endmodule

// File: tb/sim_eifc_top.sv
module sim_eifc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin = 8'hFF;
  logic [7:0]  xfer = 8'h00;
  logic        addr = 1'b0, wr = 1'b0, rd = 1'b0, rmw = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [7:0]  irq;
  logic [7:0]  en = 8'h00;
  logic [15:0] selw = 16'h0;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  eifc_top u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .xfer_done_i(xfer),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_rmw_i(rmw),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {sel[1:0], pin before, pin after, expected flag}
  localparam logic [4:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b0, 1'b1}, {2'b00, 1'b1, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1}, {2'b01, 1'b0, 1'b0, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b1}, {2'b10, 1'b1, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b0, 1'b1}, {2'b11, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(logic a, logic [15:0] d);
    addr = a; wr = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(logic a, logic m);
    addr = a; rd = 1'b1; rmw = m;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; rmw = 1'b0;
  endtask

  task automatic clear_all();
    reg_write(1'b0, {8'h00, en});
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check("R1 rdata", rdata, 16'h0000);
    check("R1 irq", {8'h0, irq}, 16'h0000);
    reg_read(1'b0, 1'b0);
    check("R1 flags/en", rdata, 16'h0000);
    reg_read(1'b1, 1'b0);
    check("R1 sel", rdata, 16'h0000);

    // R9 select word readback, absent fields read 0
    reg_write(1'b1, 16'hFFFF);
    reg_read(1'b1, 1'b0);
    check("R9 sel mask", rdata, 16'hFF03);
    reg_write(1'b1, 16'h0000);

    // R3 mode table on channel 4
    for (int v = 0; v < 8; v++) begin
      selw[9:8] = VEC[v][4:3];
      reg_write(1'b1, selw);
      pin[4] = VEC[v][2];
      tick(5);
      clear_all();
      pin[4] = VEC[v][1];
      tick(5);
      reg_read(1'b0, 1'b0);
      check($sformatf("R3 mode %0d entry %0d", VEC[v][4:3], v), {15'h0, rdata[12]}, {15'h0, VEC[v][0]});
    end
    selw[9:8] = 2'b00; reg_write(1'b1, selw);
    pin[4] = 1'b1; tick(5); clear_all();

    // R2 absent channels: enables masked, pins ignored
    reg_write(1'b0, 16'h00FF);
    en = 8'hF1;
    reg_read(1'b0, 1'b0);
    check("R2 enable mask", rdata, 16'h00F1);
    pin[3:1] = 3'b000; tick(5);
    reg_read(1'b0, 1'b0);
    check("R2 absent flags", rdata, 16'h00F1);
    check("R2 absent irq", {8'h0, irq}, 16'h0000);
    pin[3:1] = 3'b111; tick(5);
    reg_write(1'b0, 16'h0000);
    en = 8'h00;

    // R3 exact latency: rising edge on channel 0
    selw[1:0] = 2'b10; selw[15:14] = 2'b11;
    reg_write(1'b1, selw);
    pin[0] = 1'b0; tick(5); clear_all();
    pin[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_read(1'b0, 1'b0);
    check("R3 not yet set", rdata, 16'h0000);
    reg_read(1'b0, 1'b0);
    check("R3 set on third edge", rdata, 16'h0100);

    // R6 enable gating and one-stage delay
    check("R6 disabled irq", {8'h0, irq}, 16'h0000);
    reg_write(1'b0, 16'hFF01); en = 8'h01;
    check("R6 irq delay", {8'h0, irq}, 16'h0000);
    tick(1);
    check("R6 irq on", {8'h0, irq}, 16'h0001);

    // R4 write-1 no effect, write-0 clears only its channel
    pin[7] = 1'b0; tick(5); pin[7] = 1'b1; tick(5);
    reg_write(1'b0, {8'hFF, en});
    reg_read(1'b0, 1'b0);
    check("R4 write ones keep", rdata, 16'h8101);
    reg_write(1'b0, {8'h7F, en});
    reg_read(1'b0, 1'b0);
    check("R4 clear ch7 only", rdata, 16'h0101);

    // R5 read-modify-write read
    reg_read(1'b0, 1'b1);
    check("R5 rmw read", rdata, 16'hF101);
    reg_read(1'b0, 1'b0);
    check("R5 plain read", rdata, 16'h0101);

    // R7 transfer completion clears just its channel
    pin[7] = 1'b0; tick(5);
    xfer = 8'h02; tick(1); xfer = 8'h00;
    reg_read(1'b0, 1'b0);
    check("R7 absent strobe", rdata, 16'h8101);
    xfer = 8'h01; tick(1); xfer = 8'h00;
    reg_read(1'b0, 1'b0);
    check("R7 xfer clear", rdata, 16'h8001);
    tick(1);
    check("R7 irq dropped", {8'h0, irq}, 16'h0000);

    // R8 active level keeps flag through clears
    selw[15:14] = 2'b00; reg_write(1'b1, selw);
    clear_all();
    reg_read(1'b0, 1'b0);
    check("R8 level holds", rdata, 16'h8001);
    xfer = 8'h80; tick(1); xfer = 8'h00;
    reg_read(1'b0, 1'b0);
    check("R8 level vs xfer", rdata, 16'h8001);
    pin[7] = 1'b1; tick(5); clear_all();
    reg_read(1'b0, 1'b0);
    check("R8 level released", rdata, 16'h0001);

    // R8 edge detected in the same cycle as a written clear
    pin[0] = 1'b0; tick(5); clear_all();
    pin[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_write(1'b0, {8'h00, en});
    reg_read(1'b0, 1'b0);
    check("R8 edge beats clear", rdata, 16'h0101);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule